// File: doc/BRIEF.md
# Two-Stage Superscalar Register Renamer

This block maps the architectural register names of up to four instructions per clock onto physical register names. Each instruction slot carries a valid bit, two architectural source names, an optional architectural destination name and a flag saying whether that destination exists. A free-register supplier offers a small in-order list of unused physical names together with a count of how many of them are usable. The block holds the alias table. For every valid slot it returns the physical names of both sources, the freshly assigned physical name of the destination, and the mapping that destination had before, so that a reorder buffer can record it.

The work is split over two clock stages. In stage one the group is accepted, its destinations are given free names, every architectural name is compared with the destinations of older producers, and the table is read. In stage two the final selection multiplexers pick between the table value and the bypassed names, and the table is updated. Because the table write of one group lands at the end of its second stage, the group directly behind it reads a stale table. That older group's names are therefore forwarded. Results for a group taken at a clock edge appear on the outputs during the following clock cycle.

Top module: `rename_pipe`

## Requirements
- R1: After reset every output valid bit is low and architectural register i maps to physical register i.
- R2: `grp_ready` is high exactly when `free_cnt` is at least the number of slots in the presented group that are valid and carry a destination. A group is taken when `grp_valid` and `grp_ready` are both high, and `free_used` then equals that number; otherwise `free_used` is zero.
- R3: Within a taken group, a valid slot with a destination receives `free_names[r]`, where r counts the valid slots with a destination at lower slot indices (slot 0 is the oldest).
- R4: The clock cycle after a group is taken, `out_valid` equals that group's slot valid bits. After a cycle with no group taken, `out_valid` is all zero.
- R5: A source whose name matches the destination of an older valid slot in the same group receives the new name of the nearest such slot.
- R6: A source with no producer in its own group receives the latest mapping left by earlier taken groups, including the group taken in the immediately preceding cycle.
- R7: The previous mapping reported for a destination is the new name of the nearest older same-register writer in the group, or else the latest mapping left by earlier groups.
- R8: When several slots of a group write the same architectural register, the youngest slot's name is the mapping seen by later groups.
- R9: A slot that is not valid, or that has no destination, matches no consumer, consumes no free name and leaves the table unchanged.
- R10: A group presented while `grp_ready` is low has no effect on outputs or on the mappings seen by later groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A rename group is presented |
| grp_ready | output | 1 | Enough free names are offered for the presented group |
| in_vld | input | N | Per-slot instruction valid |
| in_den | input | N | Per-slot destination present |
| in_src1 | input | N x AW | First architectural source per slot |
| in_src2 | input | N x AW | Second architectural source per slot |
| in_dst | input | N x AW | Architectural destination per slot |
| free_names | input | N x PW | Offered free physical names, oldest first |
| free_cnt | input | CW | Number of offered names that are usable |
| free_used | output | CW | Number of offered names consumed this cycle |
| out_valid | output | N | Per-slot result valid (stage two) |
| out_src1 | output | N x PW | Physical name of the first source |
| out_src2 | output | N x PW | Physical name of the second source |
| out_dst_new | output | N x PW | New physical destination name (zero without a destination) |
| out_dst_old | output | N x PW | Previous mapping of the destination |

## Verification
The properties assume that the supplier's usable free names are distinct from one another. They also assume that the inputs stay steady across the clock edge at which a group is taken. The distinct-name and bypass properties only hold under these conditions. The stimulus draws free names from a rolling counter over the upper half of the physical space, so that no two names offered in one cycle coincide. It changes inputs only away from the active edge. The group patterns cover dependency chains inside a group, back-to-back groups whose table writes are still in flight, stalls, idle cycles, and holes where slots are invalid or have no destination.

// File: rtl/rn_pkg.sv
package rn_pkg;

    // lookups made per slot: two sources and one destination
    localparam int QPS   = 3;
    localparam int Q_SA  = 0;
    localparam int Q_SB  = 1;
    localparam int Q_DST = 2;

    // where the final multiplexer takes a physical name from
    typedef enum logic [1:0] {
        PICK_TABLE = 2'd0,
        PICK_CUR   = 2'd1,
        PICK_PREV  = 2'd2
    } pick_e;

    function automatic int slot_of(input int q);
        return q / QPS;
    endfunction

endpackage

// File: rtl/rn_name_alloc.sv
module rn_name_alloc #(
    parameter int N  = 4,
    parameter int PW = 7,
    parameter int CW = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]         wr,
    input  logic [N-1:0][PW-1:0] free_names,
    output logic [N-1:0][PW-1:0] new_nm,
    output logic [CW-1:0]        need
);
    logic [CW-1:0] cnt;

    // compacting assignment: writers take offered names in slot order
    always_comb begin
        cnt = '0;
        for (int k = 0; k < N; k++) begin
            new_nm[k] = free_names[cnt[IW-1:0]];
            if (wr[k]) cnt = cnt + CW'(1);
        end
        need = cnt;
    end
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
    parameter int N  = 4,
    parameter int AW = 6,
    parameter int IW = 2,
    parameter int NQ = 12
) (
    input  logic [N-1:0]         cur_wr,
    input  logic [N-1:0][AW-1:0] cur_dst,
    input  logic [N-1:0]         prev_wr,
    input  logic [N-1:0][AW-1:0] prev_dst,
    input  logic [AW-1:0]        q_name [NQ],
    output rn_pkg::pick_e        q_pick [NQ],
    output logic [IW-1:0]        q_idx  [NQ]
);
    import rn_pkg::*;

    // later loop iterations override earlier ones, so the youngest
    // older producer wins and the current group beats the previous one
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            q_pick[q] = PICK_TABLE;
            q_idx[q]  = '0;
            for (int j = 0; j < N; j++) begin
                if (prev_wr[j] && prev_dst[j] == q_name[q]) begin
                    q_pick[q] = PICK_PREV;
                    q_idx[q]  = IW'(j);
                end
            end
            for (int j = 0; j < N; j++) begin
                if (j < slot_of(q) && cur_wr[j] && cur_dst[j] == q_name[q]) begin
                    q_pick[q] = PICK_CUR;
                    q_idx[q]  = IW'(j);
                end
            end
        end
    end
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
    parameter int A  = 64,
    parameter int AW = 6,
    parameter int PW = 7,
    parameter int NR = 12,
    parameter int NW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         rd_addr [NR],
    output logic [PW-1:0]         rd_data [NR],
    input  logic [NW-1:0]         we,
    input  logic [NW-1:0][AW-1:0] wa,
    input  logic [NW-1:0][PW-1:0] wd
);
    logic [PW-1:0] mem [A];

    always_comb begin
        for (int r = 0; r < NR; r++) rd_data[r] = mem[rd_addr[r]];
    end

    // ascending port order: the youngest writer of an entry lands last
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < A; i++) mem[i] <= PW'(i);
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (we[w]) mem[wa[w]] <= wd[w];
            end
        end
    end
endmodule

// File: rtl/rn_bypass_mux.sv
module rn_bypass_mux #(
    parameter int N  = 4,
    parameter int PW = 7,
    parameter int IW = 2,
    parameter int NQ = 12
) (
    input  rn_pkg::pick_e        pick [NQ],
    input  logic [IW-1:0]        idx  [NQ],
    input  logic [PW-1:0]        tbl  [NQ],
    input  logic [N-1:0][PW-1:0] cur_nm,
    input  logic [N-1:0][PW-1:0] prev_nm,
    output logic [PW-1:0]        res  [NQ]
);
    import rn_pkg::*;

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            case (pick[q])
                PICK_CUR:  res[q] = cur_nm[idx[q]];
                PICK_PREV: res[q] = prev_nm[idx[q]];
                default:   res[q] = tbl[q];
            endcase
        end
    end
endmodule

// File: rtl/rename_pipe.sv
module rename_pipe #(
    parameter int N = 4,
    parameter int A = 64,
    parameter int P = 128
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  grp_valid,
    output logic                                  grp_ready,
    input  logic [N-1:0]                          in_vld,
    input  logic [N-1:0]                          in_den,
    input  logic [N-1:0][$clog2(A)-1:0]           in_src1,
    input  logic [N-1:0][$clog2(A)-1:0]           in_src2,
    input  logic [N-1:0][$clog2(A)-1:0]           in_dst,
    input  logic [N-1:0][$clog2(P)-1:0]           free_names,
    input  logic [$clog2(N+1)-1:0]                free_cnt,
    output logic [$clog2(N+1)-1:0]                free_used,
    output logic [N-1:0]                          out_valid,
    output logic [N-1:0][$clog2(P)-1:0]           out_src1,
    output logic [N-1:0][$clog2(P)-1:0]           out_src2,
    output logic [N-1:0][$clog2(P)-1:0]           out_dst_new,
    output logic [N-1:0][$clog2(P)-1:0]           out_dst_old
);
    import rn_pkg::*;

    localparam int AW = $clog2(A);
    localparam int PW = $clog2(P);
    localparam int CW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int NQ = N * QPS;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] dst;
        logic [PW-1:0] nm;
    } slot_t;

    typedef struct packed {
        pick_e         pick;
        logic [IW-1:0] idx;
        logic [PW-1:0] tbl;
    } qry_t;

    // ---------------- stage 1 ----------------
    logic [N-1:0]         s1_wr;
    logic [N-1:0][PW-1:0] s1_nm;
    logic [CW-1:0]        need;
    logic                 take;
    logic [AW-1:0]        q_name [NQ];
    pick_e                q_pick [NQ];
    logic [IW-1:0]        q_idx  [NQ];
    logic [PW-1:0]        q_tbl  [NQ];

    // ---------------- stage 2 ----------------
    slot_t                s2  [N];
    qry_t                 s2q [NQ];
    logic [N-1:0][PW-1:0] prev_nm;
    logic [N-1:0]         s2_wr;
    logic [N-1:0][AW-1:0] s2_dst;
    logic [N-1:0][PW-1:0] s2_nm;
    pick_e                m_pick [NQ];
    logic [IW-1:0]        m_idx  [NQ];
    logic [PW-1:0]        m_tbl  [NQ];
    logic [PW-1:0]        m_res  [NQ];

    assign s1_wr     = in_vld & in_den;
    assign grp_ready = (need <= free_cnt);
    assign take      = grp_valid && grp_ready;
    assign free_used = take ? need : '0;

    for (genvar k = 0; k < N; k++) begin : g_slot
        assign q_name[k*QPS + Q_SA]  = in_src1[k];
        assign q_name[k*QPS + Q_SB]  = in_src2[k];
        assign q_name[k*QPS + Q_DST] = in_dst[k];
        assign s2_wr[k]  = s2[k].wr;
        assign s2_dst[k] = s2[k].dst;
        assign s2_nm[k]  = s2[k].nm;
        assign out_valid[k]   = s2[k].vld;
        assign out_dst_new[k] = s2[k].wr ? s2[k].nm : '0;
        assign out_src1[k]    = m_res[k*QPS + Q_SA];
        assign out_src2[k]    = m_res[k*QPS + Q_SB];
        assign out_dst_old[k] = m_res[k*QPS + Q_DST];
    end

    for (genvar q = 0; q < NQ; q++) begin : g_qry
        assign m_pick[q] = s2q[q].pick;
        assign m_idx[q]  = s2q[q].idx;
        assign m_tbl[q]  = s2q[q].tbl;
    end

    rn_name_alloc #(.N(N), .PW(PW), .CW(CW), .IW(IW)) u_alloc (
        .wr         (s1_wr),
        .free_names (free_names),
        .new_nm     (s1_nm),
        .need       (need)
    );

    // the group now in stage 2 has not written the table yet: compare against it
    rn_dep_check #(.N(N), .AW(AW), .IW(IW), .NQ(NQ)) u_dep (
        .cur_wr   (s1_wr),
        .cur_dst  (in_dst),
        .prev_wr  (s2_wr),
        .prev_dst (s2_dst),
        .q_name   (q_name),
        .q_pick   (q_pick),
        .q_idx    (q_idx)
    );

    rn_alias_table #(.A(A), .AW(AW), .PW(PW), .NR(NQ), .NW(N)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (q_name),
        .rd_data (q_tbl),
        .we      (s2_wr),
        .wa      (s2_dst),
        .wd      (s2_nm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) s2[k] <= '0;
            for (int q = 0; q < NQ; q++) s2q[q] <= '0;
            prev_nm <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                prev_nm[k]  <= s2[k].nm;
                s2[k].vld   <= take && in_vld[k];
                s2[k].wr    <= take && s1_wr[k];
                s2[k].dst   <= in_dst[k];
                s2[k].nm    <= s1_nm[k];
            end
            for (int q = 0; q < NQ; q++) begin
                s2q[q].pick <= q_pick[q];
                s2q[q].idx  <= q_idx[q];
                s2q[q].tbl  <= q_tbl[q];
            end
        end
    end

    rn_bypass_mux #(.N(N), .PW(PW), .IW(IW), .NQ(NQ)) u_mux (
        .pick    (m_pick),
        .idx     (m_idx),
        .tbl     (m_tbl),
        .cur_nm  (s2_nm),
        .prev_nm (prev_nm),
        .res     (m_res)
    );

endmodule

// File: rtl/rename_pipe_chk.sv
module rename_pipe_chk #(
    parameter int N = 4,
    parameter int A = 64,
    parameter int P = 128
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        grp_valid,
    input logic                        grp_ready,
    input logic [N-1:0]                in_vld,
    input logic [N-1:0]                in_den,
    input logic [N-1:0][$clog2(A)-1:0] in_src1,
    input logic [N-1:0][$clog2(A)-1:0] in_dst,
    input logic [$clog2(N+1)-1:0]      free_cnt,
    input logic [$clog2(N+1)-1:0]      free_used,
    input logic [N-1:0]                out_valid,
    input logic [N-1:0][$clog2(P)-1:0] out_src1,
    input logic [N-1:0][$clog2(P)-1:0] out_dst_new,
    input logic [N-1:0][$clog2(P)-1:0] out_dst_old
);
    logic take;
    assign take = grp_valid && grp_ready;

    p_used_within_r2: assert property (@(posedge clk) disable iff (rst)
        free_used <= free_cnt);

    p_stall_consumes_none_r10: assert property (@(posedge clk) disable iff (rst)
        !grp_ready |-> free_used == '0);

    p_idle_gives_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        !take |=> out_valid == '0);

    p_valid_follows_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid == $past(in_vld));

    if (N >= 2) begin : g_pair
        p_raw_neighbour_r5: assert property (@(posedge clk) disable iff (rst)
            (take && in_vld[0] && in_den[0] && in_vld[1] && in_src1[1] == in_dst[0])
            |=> out_src1[1] == out_dst_new[0]);

        p_old_neighbour_r7: assert property (@(posedge clk) disable iff (rst)
            (take && in_vld[0] && in_den[0] && in_vld[1] && in_den[1] && in_dst[1] == in_dst[0])
            |=> out_dst_old[1] == out_dst_new[0]);
    end

    for (genvar i = 0; i < N; i++) begin : g_di
        for (genvar j = i + 1; j < N; j++) begin : g_dj
            p_new_distinct_r3: assert property (@(posedge clk) disable iff (rst)
                (take && in_vld[i] && in_den[i] && in_vld[j] && in_den[j])
                |=> out_dst_new[i] != out_dst_new[j]);
        end
    end
endmodule

bind rename_pipe rename_pipe_chk #(.N(N), .A(A), .P(P)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .grp_valid   (grp_valid),
    .grp_ready   (grp_ready),
    .in_vld      (in_vld),
    .in_den      (in_den),
    .in_src1     (in_src1),
    .in_dst      (in_dst),
    .free_cnt    (free_cnt),
    .free_used   (free_used),
    .out_valid   (out_valid),
    .out_src1    (out_src1),
    .out_dst_new (out_dst_new),
    .out_dst_old (out_dst_old)
);

// File: tb/rename_pipe_tb.sv
module rename_pipe_tb;
    typedef struct packed {
        logic [3:0]      vld;
        logic [3:0]      den;
        logic [3:0][5:0] s1;
        logic [3:0][5:0] s2;
        logic [3:0][5:0] d;
    } grp_t;

    // slot 3 is the leftmost element of every concatenation
    localparam grp_t VEC [6] = '{
        '{vld:4'b1111, den:4'b1111, s1:{6'd3,6'd2,6'd1,6'd0},
          s2:{6'd13,6'd12,6'd11,6'd10}, d:{6'd23,6'd22,6'd21,6'd20}},
        '{vld:4'b1111, den:4'b1011, s1:{6'd1,6'd1,6'd1,6'd5},
          s2:{6'd2,6'd20,6'd1,6'd6},   d:{6'd1,6'd0,6'd1,6'd1}},
        '{vld:4'b1011, den:4'b0111, s1:{6'd21,6'd1,6'd30,6'd1},
          s2:{6'd30,6'd0,6'd0,6'd21},  d:{6'd0,6'd1,6'd21,6'd30}},
        '{vld:4'b1111, den:4'b1111, s1:{6'd20,6'd2,6'd2,6'd1},
          s2:{6'd2,6'd0,6'd21,6'd0},   d:{6'd40,6'd2,6'd2,6'd2}},
        '{vld:4'b1111, den:4'b0000, s1:{6'd40,6'd2,6'd1,6'd30},
          s2:{6'd21,6'd20,6'd0,6'd3},  d:{6'd5,6'd5,6'd5,6'd5}},
        '{vld:4'b1111, den:4'b1111, s1:{6'd7,6'd7,6'd7,6'd7},
          s2:{6'd2,6'd1,6'd40,6'd3},   d:{6'd7,6'd7,6'd7,6'd7}}
    };
    localparam grp_t G_STALL = '{vld:4'b0011, den:4'b0011, s1:{6'd0,6'd0,6'd7,6'd1},
          s2:{6'd0,6'd0,6'd0,6'd0}, d:{6'd0,6'd0,6'd1,6'd7}};
    localparam grp_t G_READ  = '{vld:4'b1111, den:4'b0000, s1:{6'd0,6'd21,6'd1,6'd7},
          s2:{6'd2,6'd30,6'd40,6'd20}, d:{6'd0,6'd0,6'd0,6'd0}};
    localparam grp_t G_READ2 = '{vld:4'b0101, den:4'b0100, s1:{6'd0,6'd2,6'd0,6'd30},
          s2:{6'd0,6'd7,6'd0,6'd0}, d:{6'd0,6'd9,6'd0,6'd0}};
    localparam grp_t G_IDLE  = '0;

    string vtag [6] = '{"R1 R4", "R5 R3 R7 R9", "R6 R7 R9", "R8 R7 R5", "R2 R6 R8", "R8 R3"};

    logic            clk = 1'b0;
    logic            rst;
    logic            grp_valid;
    logic            grp_ready;
    logic [3:0]      in_vld, in_den;
    logic [3:0][5:0] in_src1, in_src2, in_dst;
    logic [3:0][6:0] free_names;
    logic [2:0]      free_cnt, free_used;
    logic [3:0]      out_valid;
    logic [3:0][6:0] out_src1, out_src2, out_dst_new, out_dst_old;

    int    mp [64];
    int    nxt;
    int    checks, fails;
    bit    done, pend;
    int    e_vld [4], e_wr [4], e_s1 [4], e_s2 [4], e_new [4], e_old [4];
    string ptag;

    always #5 clk = ~clk;

    rename_pipe #(.N(4), .A(64), .P(128)) u_dut (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .in_vld(in_vld), .in_den(in_den), .in_src1(in_src1), .in_src2(in_src2),
        .in_dst(in_dst), .free_names(free_names), .free_cnt(free_cnt),
        .free_used(free_used), .out_valid(out_valid), .out_src1(out_src1),
        .out_src2(out_src2), .out_dst_new(out_dst_new), .out_dst_old(out_dst_old)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: check the group driven last time, then drive a new one
    task automatic step(input grp_t g, input bit gv, input int cnt, input string tag);
        int need;
        int r;
        bit acc;
        @(negedge clk);
        if (pend) begin
            for (int k = 0; k < 4; k++) begin
                chk(ptag, $sformatf("valid slot %0d", k), int'(out_valid[k]), e_vld[k]);
                if (e_vld[k] != 0) begin
                    chk(ptag, $sformatf("src1 slot %0d", k), int'(out_src1[k]), e_s1[k]);
                    chk(ptag, $sformatf("src2 slot %0d", k), int'(out_src2[k]), e_s2[k]);
                end
                if (e_wr[k] != 0) begin
                    chk(ptag, $sformatf("dst_new slot %0d", k), int'(out_dst_new[k]), e_new[k]);
                    chk(ptag, $sformatf("dst_old slot %0d", k), int'(out_dst_old[k]), e_old[k]);
                end
            end
        end
        grp_valid = gv;
        in_vld    = g.vld;
        in_den    = g.den;
        in_src1   = g.s1;
        in_src2   = g.s2;
        in_dst    = g.d;
        free_cnt  = 3'(cnt);
        for (int i = 0; i < 4; i++) free_names[i] = 7'(64 + ((nxt + i) % 64));
        need = 0;
        for (int k = 0; k < 4; k++) if (g.vld[k] && g.den[k]) need++;
        acc = gv && (need <= cnt);
        #1;
        chk(tag, "grp_ready", int'(grp_ready), (need <= cnt) ? 1 : 0);
        chk(tag, "free_used", int'(free_used), acc ? need : 0);
        r = 0;
        for (int k = 0; k < 4; k++) begin
            e_vld[k] = (acc && g.vld[k]) ? 1 : 0;
            e_wr[k]  = (e_vld[k] != 0 && g.den[k]) ? 1 : 0;
            if (e_vld[k] != 0) begin
                e_s1[k] = mp[g.s1[k]];
                e_s2[k] = mp[g.s2[k]];
            end
            if (e_wr[k] != 0) begin
                e_old[k] = mp[g.d[k]];
                e_new[k] = 64 + ((nxt + r) % 64);
                r++;
                mp[g.d[k]] = e_new[k];
            end
        end
        if (acc) nxt += need;
        pend = 1'b1;
        ptag = tag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mp[i] = i;
        nxt = 0; checks = 0; fails = 0; done = 1'b0; pend = 1'b0;
        rst = 1'b1; grp_valid = 1'b0; in_vld = '0; in_den = '0;
        in_src1 = '0; in_src2 = '0; in_dst = '0; free_names = '0; free_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset out_valid", int'(out_valid), 0);
        rst = 1'b0;

        // table-driven groups, back to back
        for (int v = 0; v < 6; v++) step(VEC[v], 1'b1, 4, vtag[v]);

        // directed: stall, then a reader that must not see the stalled group
        step(G_STALL, 1'b1, 1, "R10 R2");
        step(G_READ,  1'b1, 4, "R10 R6");
        // idle cycle gives a bubble; then a reader after the bubble
        step(G_READ,  1'b0, 4, "R4");
        step(G_READ2, 1'b1, 4, "R6");
        step(G_IDLE,  1'b0, 4, "R4");
        step(G_IDLE,  1'b0, 4, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule